// File: doc/BRIEF.md
# Comparator Output Deglitcher and Transition Pulser

This block takes the raw digital output of an analog comparator and turns it into clean, single-cycle notifications. The input is asynchronous, so it is first brought into the system clock domain by a two-stage synchronizer. It then passes through an optional noise filter, which samples at a selectable rate and changes its output only after three samples in a row agree on the new level. Short disturbances therefore never reach the edge logic.

An edge detector watches the conditioned level and fires on rising transitions, on falling transitions, or on both, as configured. Each qualifying transition produces two one-cycle outputs. One is an event pulse for a peripheral linkage controller, and it is always emitted. The other is an interrupt request, and it appears only while the interrupt enable is set. The configuration inputs are plain levels that a surrounding register block drives.

Top module: `cmpflt_top`

## Requirements
- R1: During reset and after its release with the comparator input low, both pulse outputs stay 0; reset clears the synchronizer, the filter level and its sample history to 0.
- R2: With filter select 00 the filter is bypassed, and a change at the comparator input gives its pulse in the third clock cycle after the change (two synchronizer stages plus one output register).
- R3: With filter select 01 the filter samples on every clock. A clean input change gives its pulse in the sixth cycle after the change, and the filtered level moves only on a sample strobe.
- R4: A new level that lasts for fewer than three consecutive samples is discarded, and the filtered level keeps its previous value. A level that lasts exactly three samples is accepted.
- R5: Filter select 10 samples once every 8 clocks and select 11 once every 32 clocks, from a free-running prescaler. With a sample period D, the first pulse after a clean change lands between cycle 2D+4 and cycle 3D+3.
- R6: With the both-edges bit at 1, every rising and every falling transition of the filtered level gives one pulse.
- R7: With the both-edges bit at 0 and the falling-select bit at 0, only rising transitions give a pulse.
- R8: With the both-edges bit at 0 and the falling-select bit at 1, only falling transitions give a pulse.
- R9: Each qualifying transition gives exactly one pulse, one clock cycle wide, on each enabled output.
- R10: With the interrupt enable at 1, the interrupt output matches the event output cycle for cycle.
- R11: With the interrupt enable at 0, the interrupt output stays 0 while the event output still pulses on every qualifying transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_async | input | 1 | Raw comparator output, asynchronous to clk |
| cfg_fsel | input | 2 | Filter select: 00 bypass, 01 every clock, 10 every 8 clocks, 11 every 32 clocks |
| cfg_both | input | 1 | 1: pulse on both transition directions |
| cfg_fall | input | 1 | When cfg_both is 0: 0 selects rising, 1 selects falling |
| cfg_irq_en | input | 1 | Interrupt request enable |
| evt_pulse | output | 1 | One-cycle event pulse toward the linkage controller |
| irq_pulse | output | 1 | One-cycle interrupt request, gated by cfg_irq_en |

## Verification
In bypass the pulse is due three clock edges after the input is driven, and with sampling on every clock it is due six edges after. The bench drives inputs on falling edges, counts rising edges from that point, and tests the output level at each following falling edge, so it checks both that the pulse is present in the expected cycle and absent in the cycles on either side. The prescaler phase is not visible at the ports. For the divided rates the bench therefore records the cycle of the first pulse and accepts it only inside the window 2D+4 to 3D+3. The table-driven part holds each stimulus for 120 cycles, longer than the slowest settling time, and compares the number of high cycles on each output with the expected pulse count.

// File: rtl/cmpflt_pkg.sv
package cmpflt_pkg;

    typedef enum logic [1:0] {
        FSEL_OFF  = 2'b00,
        FSEL_FULL = 2'b01,
        FSEL_MID  = 2'b10,
        FSEL_SLOW = 2'b11
    } fsel_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10
    } edge_mode_e;

    typedef struct packed {
        fsel_e fsel;
        logic  both;
        logic  fall;
        logic  irq_en;
    } cfg_t;

    typedef struct packed {
        logic evt;
        logic irq;
    } pulse_t;

    localparam int unsigned NUM_RATES = 3;

    function automatic edge_mode_e decode_edge(input logic both, input logic fall);
        if (both)
            return EDGE_BOTH;
        else if (fall)
            return EDGE_FALL;
        else
            return EDGE_RISE;
    endfunction

    function automatic logic edge_hit(input edge_mode_e m, input logic prev, input logic cur);
        case (m)
            EDGE_RISE: return !prev && cur;
            EDGE_FALL: return prev && !cur;
            default:   return prev ^ cur;
        endcase
    endfunction

    function automatic logic pick_strobe(input fsel_e sel, input logic [NUM_RATES-1:0] stb);
        case (sel)
            FSEL_FULL: return stb[0];
            FSEL_MID:  return stb[1];
            FSEL_SLOW: return stb[2];
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/cmpflt_sync.sv
module cmpflt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cmpflt_prescale.sv
module cmpflt_prescale
    import cmpflt_pkg::*;
#(
    parameter int unsigned DIV_MID  = 8,
    parameter int unsigned DIV_SLOW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [NUM_RATES-1:0] strobe
);
    localparam int unsigned CW = $clog2(DIV_SLOW + 1);
    localparam int unsigned DIVS [2] = '{DIV_MID, DIV_SLOW};

    assign strobe[0] = 1'b1;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_div
            localparam logic [CW-1:0] LAST = CW'(DIVS[g] - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)                cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end
            assign strobe[g+1] = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/cmpflt_filter.sv
module cmpflt_filter
    import cmpflt_pkg::*;
#(
    parameter int unsigned NSAMP = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fsel_e                fsel,
    input  logic [NUM_RATES-1:0] strobes,
    input  logic                 din,
    output logic                 smp,
    output logic                 lvl
);
    localparam int unsigned HW = NSAMP - 1;

    logic [HW-1:0]    hist_q;
    logic [NSAMP-1:0] window;
    logic             level_q;
    logic             agree;
    logic             bypass;

    assign bypass = (fsel == FSEL_OFF);
    assign smp    = pick_strobe(fsel, strobes);
    assign window = {hist_q, din};
    assign agree  = (&window) | ~(|window);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            level_q <= 1'b0;
        end else if (bypass) begin
            hist_q  <= {HW{din}};
            level_q <= din;
        end else if (smp) begin
            hist_q  <= window[HW-1:0];
            if (agree) level_q <= din;
        end
    end

    assign lvl = bypass ? din : level_q;
endmodule

// File: rtl/cmpflt_edge.sv
module cmpflt_edge
    import cmpflt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cfg_t   cfg,
    input  logic   lvl,
    output logic   prev,
    output pulse_t pulse
);
    edge_mode_e mode;
    logic       prev_q;
    logic       hit;
    pulse_t     pulse_q;

    assign mode = decode_edge(cfg.both, cfg.fall);
    assign hit  = edge_hit(mode, prev_q, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pulse_q <= '0;
        end else begin
            prev_q      <= lvl;
            pulse_q.evt <= hit;
            pulse_q.irq <= hit & cfg.irq_en;
        end
    end

    assign prev  = prev_q;
    assign pulse = pulse_q;
endmodule

// File: rtl/cmpflt_top.sv
module cmpflt_top
    import cmpflt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned NSAMP       = 3,
    parameter int unsigned DIV_MID     = 8,
    parameter int unsigned DIV_SLOW    = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_async,
    input  logic [1:0] cfg_fsel,
    input  logic       cfg_both,
    input  logic       cfg_fall,
    input  logic       cfg_irq_en,
    output logic       evt_pulse,
    output logic       irq_pulse
);
    cfg_t                 cfg;
    logic                 sync_lvl;
    logic [NUM_RATES-1:0] strobes;
    logic                 smp_strobe;
    logic                 flt_lvl;
    logic                 edge_prev;
    pulse_t               pulses;

    assign cfg.fsel   = fsel_e'(cfg_fsel);
    assign cfg.both   = cfg_both;
    assign cfg.fall   = cfg_fall;
    assign cfg.irq_en = cfg_irq_en;

    cmpflt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_async),
        .q   (sync_lvl)
    );

    cmpflt_prescale #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobes)
    );

    cmpflt_filter #(.NSAMP(NSAMP)) u_flt (
        .clk     (clk),
        .rst     (rst),
        .fsel    (cfg.fsel),
        .strobes (strobes),
        .din     (sync_lvl),
        .smp     (smp_strobe),
        .lvl     (flt_lvl)
    );

    cmpflt_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .lvl   (flt_lvl),
        .prev  (edge_prev),
        .pulse (pulses)
    );

    assign evt_pulse = pulses.evt;
    assign irq_pulse = pulses.irq;
endmodule

// File: rtl/cmpflt_chk.sv
module cmpflt_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] fsel,
    input logic       both,
    input logic       fall,
    input logic       irq_en,
    input logic       sync_lvl,
    input logic       smp,
    input logic       lvl,
    input logic       prev,
    input logic       evt,
    input logic       irq
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!evt && !irq));

    assert_filter_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(fsel) != 2'b00 && fsel != 2'b00 && !$past(smp) && !$past(rst)) |-> (lvl == $past(lvl)));

    assert_filter_source_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(fsel) != 2'b00 && fsel != 2'b00 && !$past(rst) && lvl != $past(lvl)) |-> ($past(sync_lvl) == lvl));

    assert_rise_only_R7: assert property (@(posedge clk) disable iff (rst)
        (evt && $past(!both && !fall)) |-> prev);

    assert_fall_only_R8: assert property (@(posedge clk) disable iff (rst)
        (evt && $past(!both && fall)) |-> !prev);

    assert_irq_mirror_R10: assert property (@(posedge clk) disable iff (rst)
        $past(irq_en) |-> (irq == evt));

    assert_irq_off_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(irq_en) |-> !irq);
endmodule

bind cmpflt_top cmpflt_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .fsel     (cfg_fsel),
    .both     (cfg_both),
    .fall     (cfg_fall),
    .irq_en   (cfg_irq_en),
    .sync_lvl (sync_lvl),
    .smp      (smp_strobe),
    .lvl      (flt_lvl),
    .prev     (edge_prev),
    .evt      (evt_pulse),
    .irq      (irq_pulse)
);

// File: tb/sim_cmpflt_top.sv
module sim_cmpflt_top;
    localparam time CLK_HALF = 2ns;
    localparam int  HOLD     = 120;
    localparam int  NVEC     = 14;

    // [11:10] fsel, [9] both, [8] fall, [7] irq_en, [6] level, [5:3] evt count, [2:0] irq count
    localparam logic [11:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 3'd1},
        {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0},
        {2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0},
        {2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 3'd1},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 3'd1},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1},
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 3'd0},
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0},
        {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 3'd1},
        {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 3'd1},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1},
        {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 3'd0},
        {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_async = 1'b0;
    logic [1:0] cfg_fsel = 2'd0;
    logic       cfg_both = 1'b0;
    logic       cfg_fall = 1'b0;
    logic       cfg_irq_en = 1'b1;
    logic       evt_pulse;
    logic       irq_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int ev_cnt, iq_cnt, first_k;
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    cmpflt_top u0 (
        .clk        (clk),
        .rst        (rst),
        .cmp_async  (cmp_async),
        .cfg_fsel   (cfg_fsel),
        .cfg_both   (cfg_both),
        .cfg_fall   (cfg_fall),
        .cfg_irq_en (cfg_irq_en),
        .evt_pulse  (evt_pulse),
        .irq_pulse  (irq_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (evt_pulse) begin
                ev_cnt++;
                if (first_k == 0) first_k = k;
            end
            if (irq_pulse) iq_cnt++;
        end
    endtask

    task automatic clear_counts();
        ev_cnt = 0; iq_cnt = 0; first_k = 0;
    endtask

    task automatic config_set(input logic [1:0] s, input logic b, input logic f, input logic ie);
        cfg_fsel = s; cfg_both = b; cfg_fall = f; cfg_irq_en = ie;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset state with low input
        repeat (4) @(negedge clk);
        check("R1 evt in reset", int'(evt_pulse), 0);
        check("R1 irq in reset", int'(irq_pulse), 0);
        rst = 1'b0;
        clear_counts();
        run(12);
        check("R1 evt after reset", ev_cnt, 0);
        check("R1 irq after reset", iq_cnt, 0);

        // table walk: R6 R7 R8 R9 R10 R11 R2 R5
        for (int v = 0; v < NVEC; v++) begin
            config_set(VEC[v][11:10], VEC[v][9], VEC[v][8], VEC[v][7]);
            cmp_async = VEC[v][6];
            clear_counts();
            run(HOLD);
            check($sformatf("R9 R6 R7 R8 evt count vector %0d", v), ev_cnt, int'(VEC[v][5:3]));
            check($sformatf("R10 R11 irq count vector %0d", v), iq_cnt, int'(VEC[v][2:0]));
        end

        // R2: bypass latency, rising only, level starts at 0
        config_set(2'd0, 1'b0, 1'b0, 1'b1);
        run(4);
        cmp_async = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R2 bypass evt at cycle %0d", k), int'(evt_pulse), (k == 3) ? 1 : 0);
        end
        cmp_async = 1'b0;
        run(10);

        // R3: every-clock sampling latency
        config_set(2'd1, 1'b0, 1'b0, 1'b1);
        run(10);
        cmp_async = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R3 filtered evt at cycle %0d", k), int'(evt_pulse), (k == 6) ? 1 : 0);
        end
        cmp_async = 1'b0;
        run(20);

        // R4: two-sample glitch rejected
        clear_counts();
        cmp_async = 1'b1;
        run(2);
        cmp_async = 1'b0;
        run(40);
        check("R4 two-sample glitch evt", ev_cnt, 0);
        check("R4 two-sample glitch irq", iq_cnt, 0);

        // R4: three-sample level accepted
        clear_counts();
        cmp_async = 1'b1;
        run(3);
        cmp_async = 1'b0;
        run(40);
        check("R4 three-sample level evt", ev_cnt, 1);

        // R5: divide by 8 window
        config_set(2'd2, 1'b0, 1'b0, 1'b1);
        run(40);
        clear_counts();
        cmp_async = 1'b1;
        run(40);
        check("R5 div8 evt count", ev_cnt, 1);
        check("R5 div8 first pulse in window", int'(first_k >= 20 && first_k <= 27), 1);
        cmp_async = 1'b0;
        run(40);

        // R5: divide by 32 window
        config_set(2'd3, 1'b0, 1'b0, 1'b1);
        run(120);
        clear_counts();
        cmp_async = 1'b1;
        run(110);
        check("R5 div32 evt count", ev_cnt, 1);
        check("R5 div32 first pulse in window", int'(first_k >= 68 && first_k <= 99), 1);

        finish_run();
    end
endmodule